// File: doc/BRIEF.md
# Variable-Length Instruction Word Framer

This block sits between an instruction fetch buffer and a decoder. It takes aligned 32-bit instruction words one at a time over a ready/valid handshake and groups them into whole instructions. Each instruction is classified from its top nibble. For memory-format instructions, the opcode byte is checked against a configurable set of legal opcodes. The 4-bit addressing-mode field then decides whether a 32-bit displacement word follows. The framer emits the first word, the second word when there is one, the length in bytes, a format tag, an invalid flag, the instruction's byte address and the address of the next instruction.

The framer tracks the instruction address itself. It starts from a reset address, and on a flush it restarts at a supplied address with the two low bits cleared. A two-word instruction is held inside the framer until its displacement word arrives, so nothing appears at the output in the meantime. A flush drops a half-collected instruction and any instruction still waiting at the output. The output side is a single register stage. It stays frozen while the consumer is not ready, and in that state no further words are accepted.

Top module: `instr_word_framer`

## Requirements
- R1: The format tag follows bits 31:28 of the first word. Nibbles 0 and 1 give control (tag 0). Nibbles 2 and 3 give compare-and-branch (tag 1). Nibbles 5 to 7 give register format (tag 2). Nibbles 8 to 12 are memory format. Nibbles 4, 13, 14 and 15 are unrecognised.
- R2: The opcode of a memory-format word is bits 31:24. It is legal when bit (opcode − 0x80) of the MEM_OP_MASK parameter is set. With the default mask, exactly the even opcodes are legal. An illegal opcode makes the word invalid.
- R3: The addressing mode is bits 13:10. Mode 6 makes a memory-format word invalid, whatever its opcode.
- R4: A valid memory-format word carries tag 4 (long form) when bit 12 is set and tag 3 (short form) when bit 12 is clear. This holds independently of its length.
- R5: A valid memory-format word with mode 5 or a mode from 12 to 15 is framed with the next accepted word as its second word, and its length is 8. Every other instruction has length 4, with the second-word output at zero.
- R6: An invalid word is emitted alone, unchanged in the first-word output, with tag 5, the invalid flag set and length 4. Invalid words are unrecognised nibbles, illegal opcodes and mode 6.
- R7: Each framed instruction carries its byte address. Its next-address output equals that address plus the length. Consecutive instructions are contiguous in address.
- R8: After a synchronous active-low reset, the output is not valid, input is accepted, and the first instruction is framed at RESET_ADDR.
- R9: A flush clears the output register and discards a half-collected two-word instruction. The next instruction is then framed at the flush address with bits 1:0 forced to zero.
- R10: While the output is valid and the consumer is not ready, every output field holds its value until the transfer or a flush.
- R11: No word is accepted during a flush or while the output is held. After the first word of a two-word instruction is accepted, the output stays not valid until the second word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Restart framing at flush_addr |
| flush_addr | input | ADDR_W | Restart byte address (bits 1:0 ignored) |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Framer accepts the input word |
| in_word | input | 32 | Instruction word from fetch |
| out_valid | output | 1 | Framed instruction present |
| out_ready | input | 1 | Consumer takes the framed instruction |
| out_word0 | output | 32 | First instruction word |
| out_word1 | output | 32 | Displacement word, zero for one-word instructions |
| out_len | output | 4 | Length in bytes, 4 or 8 |
| out_fmt | output | 3 | Format tag |
| out_invalid | output | 1 | Word not a recognised instruction |
| out_addr | output | ADDR_W | Byte address of the instruction |
| out_next_addr | output | ADDR_W | Byte address of the following instruction |

## Verification
The pending-word register and the address counter are the internal state that matters. A wrong pending flag pairs the wrong two words. The next framed instruction then shows the wrong second word and length, and every later address is shifted, so a single error keeps showing in all following outputs until a flush. A wrong address counter shows in the first address after reset or flush, or as a break between one next-address and the following address. A held output that drifts, or input accepted while the output is held, shows up within one cycle as a changed field or a lost word.

// File: rtl/iwf_pkg.sv
// Package: shared types and constants of the instruction word framer.
// Assumes 32-bit instruction words with fixed field positions.
package iwf_pkg;

    localparam int WORD_W       = 32;
    localparam int MEM_OP_FIRST = 8'h80;
    localparam int MEM_OP_SPAN  = 80;   // opcodes 0x80..0xCF
    localparam int LEN_W        = 4;

    typedef enum logic [2:0] {
        FMT_CTRL      = 3'd0,
        FMT_CMPBR     = 3'd1,
        FMT_REG       = 3'd2,
        FMT_MEM_SHORT = 3'd3,
        FMT_MEM_LONG  = 3'd4,
        FMT_DATA      = 3'd5
    } fmt_e;

endpackage

// File: rtl/iwf_decode.sv
// Module: iwf_decode
// Classifies one instruction word. It produces the format tag, the invalid
// flag and whether a displacement word follows.
// Assumes: purely combinational; the field positions are fixed by the format.
module iwf_decode
    import iwf_pkg::*;
#(
    parameter logic [MEM_OP_SPAN-1:0] MEM_OP_MASK = {40{2'b01}}
) (
    input  logic [WORD_W-1:0] word,
    output fmt_e              fmt,
    output logic              invalid,
    output logic              two_word
);

    localparam int IDX_W = 7;

    logic [7:0]       opcode;
    logic [3:0]       mode;
    logic [IDX_W-1:0] op_idx;
    logic [127:0]     mask_ext;
    logic             op_legal;

    // Extract the opcode, the mode and the table lookup
    always_comb begin
        opcode   = word[31:24];
        mode     = word[13:10];
        op_idx   = IDX_W'(opcode - 8'(MEM_OP_FIRST));
        mask_ext = 128'(MEM_OP_MASK);
        op_legal = mask_ext[op_idx];
    end

    // Map the top nibble to a format and resolve the memory-format length
    always_comb begin
        fmt      = FMT_DATA;
        invalid  = 1'b1;
        two_word = 1'b0;
        case (word[31:28])
            4'h0, 4'h1: begin
                fmt     = FMT_CTRL;
                invalid = 1'b0;
            end
            4'h2, 4'h3: begin
                fmt     = FMT_CMPBR;
                invalid = 1'b0;
            end
            4'h5, 4'h6, 4'h7: begin
                fmt     = FMT_REG;
                invalid = 1'b0;
            end
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC: begin
                if (op_legal && (mode != 4'd6)) begin
                    invalid  = 1'b0;
                    fmt      = word[12] ? FMT_MEM_LONG : FMT_MEM_SHORT;
                    two_word = (mode == 4'd5) || (mode >= 4'd12);
                end
            end
            default: begin
                fmt     = FMT_DATA;
                invalid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/iwf_frame_ctrl.sv
// Module: iwf_frame_ctrl
// Collects words into instructions. It holds the first word of a two-word
// instruction, keeps the running byte address and drives the registered
// output stage with ready/valid.
// Assumes: decode inputs describe in_word in the same cycle; ADDR_W >= 3.
module iwf_frame_ctrl
    import iwf_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(32'h0000_1000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  fmt_e              dec_fmt,
    input  logic              dec_invalid,
    input  logic              dec_two,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word0,
    output logic [WORD_W-1:0] out_word1,
    output logic [LEN_W-1:0]  out_len,
    output fmt_e              out_fmt,
    output logic              out_invalid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] out_next_addr
);

    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] BASE  = {RESET_ADDR[ADDR_W-1:2], 2'b00};

    logic              pend_q;
    logic [WORD_W-1:0] pend_word_q;
    fmt_e              pend_fmt_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic              can_load;
    logic              take;

    // Accept a word only when the output slot is free or draining this cycle
    always_comb begin
        can_load = !out_valid || out_ready;
        in_ready = !flush && can_load;
        take     = in_valid && in_ready;
    end

    // Pending-word, address and output register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q        <= 1'b0;
            pend_word_q   <= '0;
            pend_fmt_q    <= FMT_DATA;
            cur_addr_q    <= BASE;
            out_valid     <= 1'b0;
            out_word0     <= '0;
            out_word1     <= '0;
            out_len       <= '0;
            out_fmt       <= FMT_DATA;
            out_invalid   <= 1'b0;
            out_addr      <= '0;
            out_next_addr <= '0;
        end else if (flush) begin
            pend_q     <= 1'b0;
            out_valid  <= 1'b0;
            cur_addr_q <= {flush_addr[ADDR_W-1:2], 2'b00};
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (take) begin
                if (pend_q) begin
                    pend_q        <= 1'b0;
                    out_valid     <= 1'b1;
                    out_word0     <= pend_word_q;
                    out_word1     <= in_word;
                    out_len       <= LEN_W'(8);
                    out_fmt       <= pend_fmt_q;
                    out_invalid   <= 1'b0;
                    out_addr      <= cur_addr_q;
                    out_next_addr <= cur_addr_q + STEP2;
                    cur_addr_q    <= cur_addr_q + STEP2;
                end else if (dec_two) begin
                    pend_q      <= 1'b1;
                    pend_word_q <= in_word;
                    pend_fmt_q  <= dec_fmt;
                end else begin
                    out_valid     <= 1'b1;
                    out_word0     <= in_word;
                    out_word1     <= '0;
                    out_len       <= LEN_W'(4);
                    out_fmt       <= dec_fmt;
                    out_invalid   <= dec_invalid;
                    out_addr      <= cur_addr_q;
                    out_next_addr <= cur_addr_q + STEP1;
                    cur_addr_q    <= cur_addr_q + STEP1;
                end
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_word0)
        && $stable(out_word1) && $stable(out_len) && $stable(out_addr))); // R10

    AST_TWO_WORD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !pend_q && dec_two) |=> (!out_valid && pend_q)); // R11

    AST_LONG_LEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_W'(8)) |-> (!out_invalid && out_fmt == FMT_MEM_LONG)); // R5

    AST_INVALID_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_len == LEN_W'(4) && out_fmt == FMT_DATA)); // R6

    AST_ADDR_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !flush) |=> (!out_valid || out_addr == $past(out_next_addr))); // R7

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[1:0] == 2'b00)); // R7

    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && !pend_q)); // R9

endmodule

// File: rtl/instr_word_framer.sv
// Module: instr_word_framer (top)
// Frames a stream of 32-bit instruction words into one- or two-word
// instructions with length, format tag, invalid flag and addresses.
// Assumes: words arrive in program order; a flush marks a new start address.
module instr_word_framer
    import iwf_pkg::*;
#(
    parameter int                     ADDR_W      = 32,
    parameter logic [ADDR_W-1:0]      RESET_ADDR  = ADDR_W'(32'h0000_1000),
    parameter logic [MEM_OP_SPAN-1:0] MEM_OP_MASK = {40{2'b01}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_word0,
    output logic [31:0]       out_word1,
    output logic [3:0]        out_len,
    output logic [2:0]        out_fmt,
    output logic              out_invalid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] out_next_addr
);

    fmt_e dec_fmt;
    logic dec_invalid;
    logic dec_two;
    fmt_e fmt_q;

    iwf_decode #(
        .MEM_OP_MASK(MEM_OP_MASK)
    ) decode_i (
        .word     (in_word),
        .fmt      (dec_fmt),
        .invalid  (dec_invalid),
        .two_word (dec_two)
    );

    iwf_frame_ctrl #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .flush_addr    (flush_addr),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_word       (in_word),
        .dec_fmt       (dec_fmt),
        .dec_invalid   (dec_invalid),
        .dec_two       (dec_two),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_word0     (out_word0),
        .out_word1     (out_word1),
        .out_len       (out_len),
        .out_fmt       (fmt_q),
        .out_invalid   (out_invalid),
        .out_addr      (out_addr),
        .out_next_addr (out_next_addr)
    );

    // Expose the format tag as a plain vector
    always_comb out_fmt = fmt_q;

endmodule

// File: tb/instr_word_framer_tb.sv
// Bench: sweeps every opcode byte against every addressing mode under two
// back-pressure patterns, then runs directed stall, hold and flush cases.
module instr_word_framer_tb_top;

    localparam logic [31:0] RST_ADDR = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] flush_addr = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word0, out_word1, out_addr, out_next_addr;
    logic [3:0]  out_len;
    logic [2:0]  out_fmt;
    logic        out_invalid;

    instr_word_framer dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_word0(out_word0),
        .out_word1(out_word1), .out_len(out_len), .out_fmt(out_fmt),
        .out_invalid(out_invalid), .out_addr(out_addr), .out_next_addr(out_next_addr)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [3:0]  len;
        logic [2:0]  fmt;
        logic        inv;
        logic [31:0] addr;
        logic [31:0] nxt;
    } exp_t;

    exp_t        expq[$];
    string       tagq[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          rdy_mode = 0;
    bit          mon_en = 1'b0;
    bit          done = 1'b0;
    logic [31:0] exp_addr;
    bit          held = 1'b0;
    logic [31:0] s_w0, s_w1, s_addr;
    logic [3:0]  s_len;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Independent model of the classification rules
    task automatic model(input logic [31:0] w, output logic [2:0] fmt,
                         output logic inv, output logic two);
        logic [3:0] nib;
        logic [3:0] md;
        nib = w[31:28];
        md  = w[13:10];
        fmt = 3'd5; inv = 1'b1; two = 1'b0;
        if (nib <= 4'd1) begin fmt = 3'd0; inv = 1'b0; end
        else if (nib <= 4'd3) begin fmt = 3'd1; inv = 1'b0; end
        else if (nib >= 4'd5 && nib <= 4'd7) begin fmt = 3'd2; inv = 1'b0; end
        else if (nib >= 4'd8 && nib <= 4'd12) begin
            if (w[24] == 1'b0 && md != 4'd6) begin
                inv = 1'b0;
                fmt = w[12] ? 3'd4 : 3'd3;
                two = (md == 4'd5) || (md >= 4'd12);
            end
        end
    endtask

    // Monitor: sets back-pressure, then checks holds and transfers
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
        #2;
        if (rst_n && mon_en) begin
            if (held) begin
                chk(out_valid == 1'b1, "R10", "held valid", 64'(out_valid), 64'd1);
                chk({out_w_cat()} == {s_w0, s_w1}, "R10", "held words",
                    {out_word0, out_word1}, {s_w0, s_w1});
                chk(out_addr == s_addr && out_len == s_len, "R10", "held addr/len",
                    64'(out_addr), 64'(s_addr));
            end
            if (out_valid && !out_ready) begin
                chk(in_ready == 1'b0, "R11", "in_ready while held", 64'(in_ready), 64'd0);
                held = 1'b1;
                s_w0 = out_word0; s_w1 = out_word1; s_addr = out_addr; s_len = out_len;
            end else begin
                held = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R7", "unexpected output", 64'(out_word0), 64'd0);
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(out_word0 == e.w0, t, "word0", 64'(out_word0), 64'(e.w0));
                    chk(out_word1 == e.w1, t, "word1", 64'(out_word1), 64'(e.w1));
                    chk(out_len == e.len, t, "len", 64'(out_len), 64'(e.len));
                    chk(out_fmt == e.fmt, t, "fmt", 64'(out_fmt), 64'(e.fmt));
                    chk(out_invalid == e.inv, t, "invalid", 64'(out_invalid), 64'(e.inv));
                    chk(out_addr == e.addr, t, "addr", 64'(out_addr), 64'(e.addr));
                    chk(out_next_addr == e.nxt, t, "next addr", 64'(out_next_addr), 64'(e.nxt));
                end
            end
        end
    end

    function automatic logic [63:0] out_w_cat();
        return {out_word0, out_word1};
    endfunction

    // Drive one word; called at a falling edge, returns at a falling edge
    task automatic send(input logic [31:0] w);
        in_word  = w;
        in_valid = 1'b1;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Predict and drive one instruction (with displacement word if needed)
    task automatic issue(input logic [31:0] w, input string tag);
        logic [2:0] f;
        logic       inv;
        logic       two;
        exp_t       e;
        model(w, f, inv, two);
        e.w0  = w;
        e.w1  = two ? (w ^ 32'hC3A5_5A3C) : 32'h0;
        e.len = two ? 4'd8 : 4'd4;
        e.fmt = f;
        e.inv = inv;
        e.addr = exp_addr;
        e.nxt = exp_addr + 32'(e.len);
        exp_addr = e.nxt;
        expq.push_back(e);
        tagq.push_back(tag);
        send(w);
        if (two) send(w ^ 32'hC3A5_5A3C);
    endtask

    task automatic do_flush(input logic [31:0] a);
        flush = 1'b1;
        flush_addr = a;
        @(negedge clk);
        flush = 1'b0;
        held = 1'b0;
        expq.delete();
        tagq.delete();
        exp_addr = {a[31:2], 2'b00};
    endtask

    task automatic drain();
        rdy_mode = 0;
        for (int k = 0; k < 50 && expq.size() != 0; k++) @(negedge clk);
        @(negedge clk);
        chk(expq.size() == 0, "R7", "outstanding instructions", 64'(expq.size()), 64'd0);
    endtask

    initial begin
        exp_addr = RST_ADDR;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(out_valid == 1'b0, "R8", "valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R8", "ready after reset", 64'(in_ready), 64'd1);
        @(negedge clk);
        mon_en = 1'b1;

        // R8: the first instruction is framed at the reset address
        issue(32'h1000_0000, "R8");
        drain();

        // Directed: R2 odd opcode, R3 mode 6, R4 short/long forms, R5 lengths
        issue(32'h8100_0000, "R2");
        issue(32'h8000_1800, "R3");
        issue(32'h8000_0000, "R4");
        issue(32'h8000_1000, "R4");
        issue(32'h8000_1C00, "R4");
        issue(32'h8200_1400, "R5");
        issue(32'hC400_3C00, "R5");
        issue(32'h4000_0000, "R6");
        issue(32'hF000_3C00, "R6");
        drain();

        // Sweep every top byte against every mode, rotating back-pressure
        for (int top = 0; top < 256; top++) begin
            rdy_mode = top % 2;
            for (int md = 0; md < 16; md++) begin
                logic [31:0] w;
                w = {8'(top), 10'(top * 7 + md), 4'(md), 10'(md * 37 + top)};
                issue(w, "R1/R5/R6/R7");
            end
        end
        drain();

        // R11: first word of a two-word instruction produces no output alone
        issue(32'h9000_3000, "R11");
        drain();
        rdy_mode = 0;
        send(32'h8000_3400);
        #2;
        chk(out_valid == 1'b0, "R11", "valid after first word", 64'(out_valid), 64'd0);
        @(negedge clk);
        #2;
        chk(out_valid == 1'b0, "R11", "valid while waiting", 64'(out_valid), 64'd0);
        // R9: a flush discards the half-collected instruction
        @(negedge clk);
        do_flush(32'h0000_2003);
        issue(32'h2000_0000, "R9");
        issue(32'h8000_1400, "R9");
        drain();

        // R9/R10: a held output is dropped by a flush
        rdy_mode = 2;
        @(negedge clk);
        issue(32'h5000_0000, "R10");
        repeat (3) @(negedge clk);
        do_flush(32'h0000_4000);
        #2;
        chk(out_valid == 1'b0, "R9", "valid after flush", 64'(out_valid), 64'd0);
        @(negedge clk);
        rdy_mode = 0;
        @(negedge clk);
        issue(32'h0100_0000, "R9");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule